// File: doc/BRIEF.md
# I2C Memory Transaction Sequencer

This block turns one request into a complete I2C transaction against an addressable memory device. It does not toggle the bus itself. It drives a bit-level master engine with four commands: START, STOP, write one byte and read one byte. Each command is issued as a single-cycle strobe. The sequencer then waits for the engine's completion pulse, which also carries the acknowledge bit that was sampled and the byte that was read.

A request names the following:
- a 7-bit device address;
- a register address of zero to `ADDR_BYTES` bytes, sent most significant byte first;
- a byte count;
- an operation, which is write, read or probe.

Write data arrives on a valid/ready input stream and read data leaves on a valid/ready output stream. For reads, a configuration input chooses how the address phase turns into the read phase: STOP followed by START, or a repeated START alone. Register-address bits above the selected address length can be folded into the low device-address bits through a parameter mask. This serves memories that hide high address bits in the device address.

When the transaction ends, a one-cycle `done` pulse presents an error flag and a count of the data-phase NACKs seen on writes. A probe sends only the address byte, to find out whether a device answers.

Top module: `i2cseq_top`

## Requirements
- R1: A read with address length N>0 issues START, WRITE {dev,0}, the N register bytes most significant first, the turnaround, WRITE {dev,1}, and then the data phase. Command encodings on `cmd_op` are 0=START, 1=STOP, 2=WRITE, 3=READ. `req_op` encodes 0=write, 1=read, 2=probe.
- R2: A read with address length 0 goes from START straight to WRITE {dev,1}, with no address-write phase.
- R3: The read turnaround is STOP followed by START when `cfg_rep_start`=0, and START alone when it is 1.
- R4: Every READ command carries `cmd_nack`=0 (ACK), except the last one of the transfer, which carries `cmd_nack`=1. A STOP follows the last READ.
- R5: A NACK on either device-address byte is followed by STOP and then `done` with `st_err`=1. No further byte is sent.
- R6: A NACK on a register-address byte ends the transaction at once with `st_err`=1 and no STOP.
- R7: In the write data phase a NACKed byte does not stop the transfer. All bytes are sent, then STOP, and `st_nacks` equals the number of NACKed data bytes with `st_err`=0.
- R8: A probe issues START, WRITE {dev,0} and STOP. `st_err`=0 means the device acknowledged and `st_err`=1 means it did not.
- R9: The device address sent is `req_dev` OR (the register-address bits from bit 8*N upward, masked by `OVF_MASK`).
- R10: `req_ready` is high only while idle. A request is taken only then. `done` lasts exactly one cycle and is followed by idle.
- R11: A write with byte count 0 sends the address phases and then STOP, and consumes nothing from the write stream.
- R12: Read bytes appear on `rd_data` in bus order. `rd_data` holds steady while `rd_valid` is high and `rd_ready` is low.
- R13: Write bytes are taken from the write stream in order, one per WRITE command in the data phase. Exactly the byte count is consumed.
- R14: At most one engine command is outstanding. `cmd_valid` never stays high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request taken |
| req_op | input | 2 | 0 write, 1 read, 2 probe |
| req_dev | input | 7 | Device address |
| req_reg_addr | input | 8*ADDR_BYTES | Register address |
| req_alen | input | $clog2(ADDR_BYTES+1) | Register address length in bytes, clamped to ADDR_BYTES |
| req_len | input | LEN_W | Data byte count |
| cfg_rep_start | input | 1 | 1 selects repeated START before the read phase |
| cmd_valid | output | 1 | Command strobe to the bit engine |
| cmd_op | output | 2 | Command code |
| cmd_byte | output | 8 | Byte for a WRITE command |
| cmd_nack | output | 1 | Acknowledge level for a READ command (1 = NACK) |
| eng_done | input | 1 | Engine finished the outstanding command |
| eng_nack | input | 1 | NACK sampled on a WRITE command |
| eng_rdata | input | 8 | Byte returned by a READ command |
| wr_valid | input | 1 | Write stream valid |
| wr_ready | output | 1 | Write stream ready |
| wr_data | input | 8 | Write stream byte |
| rd_valid | output | 1 | Read stream valid |
| rd_ready | input | 1 | Read stream ready |
| rd_data | output | 8 | Read stream byte |
| done | output | 1 | One-cycle completion pulse |
| st_err | output | 1 | Error flag, valid with done |
| st_nacks | output | NACK_W | Write data NACK count, valid with done |

## Verification
The engine's completion pulse and the stream handshakes can land in the same cycle that the sequencer decides its next step. The sharpest case is an engine NACK on the last write byte arriving in the cycle that the byte counter reaches zero: the count must be incremented and the STOP chosen together. The bench provokes this with random engine latency, random stream stalls and random NACK patterns, including a NACK on the final data byte. It judges each transaction by comparing the full logged command list, the NACK count and the read stream against a model built from the request.

// File: rtl/i2cseq_pkg.sv
// Shared encodings for the I2C transaction sequencer.
package i2cseq_pkg;
    // Commands understood by the bit-level engine.
    typedef enum logic [1:0] {
        CMD_START = 2'd0,
        CMD_STOP  = 2'd1,
        CMD_WR    = 2'd2,
        CMD_RD    = 2'd3
    } cmd_e;

    // Sequencer states; command states issue once and wait for eng_done.
    typedef enum logic [3:0] {
        S_IDLE, S_START, S_DEVW, S_REGA, S_TSTOP, S_TSTART, S_DEVR,
        S_WGET, S_WDATA, S_RDATA, S_RDELIV, S_STOP, S_DONE
    } state_e;
endpackage

// File: rtl/i2cseq_addr_fold.sv
// Folds register-address bits above the used address length into the
// low device-address bits through a constant mask.
// Assumes alen is already clamped to ADDR_BYTES.
module i2cseq_addr_fold #(
    parameter int         ADDR_BYTES = 4,
    parameter logic [6:0] OVF_MASK   = 7'h03,
    localparam int        REG_W      = 8 * ADDR_BYTES,
    localparam int        ALEN_W     = $clog2(ADDR_BYTES + 1)
) (
    input  logic [6:0]        dev_in,
    input  logic [REG_W-1:0]  reg_addr,
    input  logic [ALEN_W-1:0] alen,
    output logic [6:0]        dev_out
);
    logic [REG_W+7:0] ext;

    // Shift the unused upper address bits down and merge them in.
    always_comb begin
        ext     = {8'h00, reg_addr} >> (int'(alen) * 8);
        dev_out = dev_in | (ext[6:0] & OVF_MASK);
    end
endmodule

// File: rtl/i2cseq_sat_ctr.sv
// Saturating event counter with synchronous clear.
// Assumes clr and inc never both matter in one cycle (clr wins).
module i2cseq_sat_ctr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count
);
    // Count up on inc, stop at all-ones.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            count <= '0;
        else if (inc && count != {W{1'b1}})
            count <= count + W'(1);
    end
endmodule

// File: rtl/i2cseq_top.sv
// I2C memory transaction sequencer. Accepts a request while idle and
// drives a bit-level engine through START/STOP/WRITE/READ commands,
// one outstanding at a time. Assumes the engine raises eng_done no
// earlier than one cycle after a command strobe.
module i2cseq_top #(
    parameter int         ADDR_BYTES = 4,
    parameter int         LEN_W      = 8,
    parameter int         NACK_W     = 8,
    parameter logic [6:0] OVF_MASK   = 7'h03,
    localparam int        REG_W      = 8 * ADDR_BYTES,
    localparam int        ALEN_W     = $clog2(ADDR_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [6:0]        req_dev,
    input  logic [REG_W-1:0]  req_reg_addr,
    input  logic [ALEN_W-1:0] req_alen,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              cfg_rep_start,
    output logic              cmd_valid,
    output logic [1:0]        cmd_op,
    output logic [7:0]        cmd_byte,
    output logic              cmd_nack,
    input  logic              eng_done,
    input  logic              eng_nack,
    input  logic [7:0]        eng_rdata,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [7:0]        wr_data,
    output logic              rd_valid,
    input  logic              rd_ready,
    output logic [7:0]        rd_data,
    output logic              done,
    output logic              st_err,
    output logic [NACK_W-1:0] st_nacks
);
    import i2cseq_pkg::*;

    state_e             state;
    logic               wait_q;
    logic [6:0]         dev_q;
    logic [REG_W-1:0]   reg_q;
    logic [ALEN_W-1:0]  alen_q, idx_q, alen_c;
    logic [LEN_W-1:0]   remain_q;
    logic               is_read_q, is_probe_q, rep_q, err_q;
    logic [7:0]         byte_q, rd_q;
    logic [6:0]         dev_fold;
    logic [REG_W-1:0]   reg_sh;
    logic               cmd_state, step, accept, nack_inc;
    logic               last_byte;

    // Clamp the address length to the supported maximum.
    assign alen_c = (req_alen > ALEN_W'(ADDR_BYTES)) ? ALEN_W'(ADDR_BYTES) : req_alen;

    i2cseq_addr_fold #(.ADDR_BYTES(ADDR_BYTES), .OVF_MASK(OVF_MASK)) u_fold (
        .dev_in   (req_dev),
        .reg_addr (req_reg_addr),
        .alen     (alen_c),
        .dev_out  (dev_fold)
    );

    assign accept   = (state == S_IDLE) && req_valid;
    assign step     = wait_q && eng_done;
    assign nack_inc = (state == S_WDATA) && step && eng_nack;

    i2cseq_sat_ctr #(.W(NACK_W)) u_nacks (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (accept),
        .inc   (nack_inc),
        .count (st_nacks)
    );

    // Decode the command a state issues and its payload.
    always_comb begin
        reg_sh    = reg_q >> {idx_q, 3'b000};
        last_byte = (remain_q == LEN_W'(1));
        cmd_state = 1'b1;
        cmd_op    = CMD_WR;
        cmd_byte  = 8'h00;
        unique case (state)
            S_START, S_TSTART: cmd_op = CMD_START;
            S_TSTOP, S_STOP:   cmd_op = CMD_STOP;
            S_DEVW:            cmd_byte = {dev_q, 1'b0};
            S_DEVR:            cmd_byte = {dev_q, 1'b1};
            S_REGA:            cmd_byte = reg_sh[7:0];
            S_WDATA:           cmd_byte = byte_q;
            S_RDATA:           cmd_op = CMD_RD;
            default:           cmd_state = 1'b0;
        endcase
        cmd_valid = cmd_state && !wait_q;
        cmd_nack  = (state == S_RDATA) && last_byte;
    end

    assign req_ready = (state == S_IDLE);
    assign wr_ready  = (state == S_WGET);
    assign rd_valid  = (state == S_RDELIV);
    assign rd_data   = rd_q;
    assign done      = (state == S_DONE);
    assign st_err    = err_q;

    // Transaction sequencing: one command at a time, advance on eng_done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= S_IDLE;
            wait_q     <= 1'b0;
            dev_q      <= '0;
            reg_q      <= '0;
            alen_q     <= '0;
            idx_q      <= '0;
            remain_q   <= '0;
            is_read_q  <= 1'b0;
            is_probe_q <= 1'b0;
            rep_q      <= 1'b0;
            err_q      <= 1'b0;
            byte_q     <= '0;
            rd_q       <= '0;
        end else begin
            if (cmd_valid)
                wait_q <= 1'b1;
            else if (step)
                wait_q <= 1'b0;
            unique case (state)
                S_IDLE: if (req_valid) begin
                    dev_q      <= dev_fold;
                    reg_q      <= req_reg_addr;
                    alen_q     <= alen_c;
                    remain_q   <= req_len;
                    is_read_q  <= (req_op == 2'd1);
                    is_probe_q <= req_op[1];
                    rep_q      <= cfg_rep_start;
                    err_q      <= 1'b0;
                    state      <= S_START;
                end
                S_START: if (step)
                    state <= (is_read_q && alen_q == '0) ? S_DEVR : S_DEVW;
                S_DEVW: if (step) begin
                    if (eng_nack) begin
                        err_q <= 1'b1;
                        state <= S_STOP;
                    end else if (is_probe_q) begin
                        state <= S_STOP;
                    end else if (alen_q != '0) begin
                        idx_q <= alen_q - ALEN_W'(1);
                        state <= S_REGA;
                    end else begin
                        state <= (remain_q == '0) ? S_STOP : S_WGET;
                    end
                end
                S_REGA: if (step) begin
                    if (eng_nack) begin
                        err_q <= 1'b1;
                        state <= S_DONE;
                    end else if (idx_q != '0) begin
                        idx_q <= idx_q - ALEN_W'(1);
                    end else if (is_read_q) begin
                        state <= rep_q ? S_TSTART : S_TSTOP;
                    end else begin
                        state <= (remain_q == '0) ? S_STOP : S_WGET;
                    end
                end
                S_TSTOP:  if (step) state <= S_TSTART;
                S_TSTART: if (step) state <= S_DEVR;
                S_DEVR: if (step) begin
                    if (eng_nack) begin
                        err_q <= 1'b1;
                        state <= S_STOP;
                    end else begin
                        state <= (remain_q == '0) ? S_STOP : S_RDATA;
                    end
                end
                S_WGET: if (wr_valid) begin
                    byte_q <= wr_data;
                    state  <= S_WDATA;
                end
                S_WDATA: if (step) begin
                    remain_q <= remain_q - LEN_W'(1);
                    state    <= last_byte ? S_STOP : S_WGET;
                end
                S_RDATA: if (step) begin
                    rd_q  <= eng_rdata;
                    state <= S_RDELIV;
                end
                S_RDELIV: if (rd_ready) begin
                    remain_q <= remain_q - LEN_W'(1);
                    state    <= last_byte ? S_STOP : S_RDATA;
                end
                S_STOP: if (step) state <= S_DONE;
                S_DONE: state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/i2cseq_chk.sv
// Protocol checker for i2cseq_top, attached by bind.
// Assumes it sees only top-level ports.
module i2cseq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_ready,
    input logic       cmd_valid,
    input logic       done,
    input logic       wr_ready,
    input logic       rd_valid,
    input logic       rd_ready,
    input logic [7:0] rd_data
);
    // R10
    idle_no_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !cmd_valid);
    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && req_ready));
    // R14
    cmd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);
    // R12
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));
    // R13
    wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ready |-> (!cmd_valid && !rd_valid));
endmodule

bind i2cseq_top i2cseq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .cmd_valid (cmd_valid),
    .done      (done),
    .wr_ready  (wr_ready),
    .rd_valid  (rd_valid),
    .rd_ready  (rd_ready),
    .rd_data   (rd_data)
);

// File: tb/i2cseq_top_bench.sv
// Self-checking bench: engine model with random latency and NACK
// patterns, random stream stalls, directed corner cases.
module i2cseq_top_bench;
    localparam int         AB   = 4;
    localparam logic [6:0] MASK = 7'h03;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        req_valid = 0;
    logic        req_ready;
    logic [1:0]  req_op = 0;
    logic [6:0]  req_dev = 0;
    logic [31:0] req_reg_addr = 0;
    logic [2:0]  req_alen = 0;
    logic [7:0]  req_len = 0;
    logic        cfg_rep_start = 0;
    logic        cmd_valid;
    logic [1:0]  cmd_op;
    logic [7:0]  cmd_byte;
    logic        cmd_nack;
    logic        eng_done = 0;
    logic        eng_nack = 0;
    logic [7:0]  eng_rdata = 0;
    logic        wr_valid = 0;
    logic        wr_ready;
    logic [7:0]  wr_data = 0;
    logic        rd_valid;
    logic        rd_ready = 0;
    logic [7:0]  rd_data;
    logic        done;
    logic        st_err;
    logic [7:0]  st_nacks;

    always #5 clk = ~clk;

    i2cseq_top #(.ADDR_BYTES(AB), .LEN_W(8), .NACK_W(8), .OVF_MASK(MASK)) u_i2cseq_top (.*);

    int checks = 0;
    int fails  = 0;
    bit hung   = 0;

    // Engine model state and command log.
    logic [10:0] log_q   [64];
    logic [10:0] exp_q   [64];
    logic [7:0]  wdata   [32];
    logic [7:0]  rd_got  [32];
    int          log_n, exp_n, widx, ridx, rd_n, wptr, pend, hold_viol;
    logic [31:0] nack_vec;
    logic        exp_err;
    int          exp_nk, exp_wused, exp_rcnt;
    logic        prev_hold;
    logic [7:0]  prev_data;

    function automatic logic [7:0] rexp(int k);
        return 8'h5A ^ 8'(k * 37);
    endfunction

    // Engine: log each command, answer after 1..3 cycles.
    always @(posedge clk) begin
        eng_done <= 1'b0;
        if (!rst_n) begin
            pend = 0;
        end else begin
            if (pend > 0) begin
                pend = pend - 1;
                if (pend == 0) eng_done <= 1'b1;
            end
            if (cmd_valid) begin
                if (cmd_op == 2'd3) log_q[log_n % 64] = {2'd3, 8'h00, cmd_nack};
                else if (cmd_op == 2'd2) log_q[log_n % 64] = {2'd2, cmd_byte, 1'b0};
                else log_q[log_n % 64] = {cmd_op, 8'h00, 1'b0};
                log_n = log_n + 1;
                eng_nack <= 1'b0;
                if (cmd_op == 2'd2) begin
                    eng_nack <= nack_vec[widx % 32];
                    widx = widx + 1;
                end else if (cmd_op == 2'd3) begin
                    eng_rdata <= rexp(ridx);
                    ridx = ridx + 1;
                end
                pend = 1 + int'($urandom_range(0, 2));
            end
        end
    end

    // Stream monitors at the clock edge.
    always @(posedge clk) begin
        if (rst_n) begin
            if (prev_hold && !(rd_valid && rd_data == prev_data)) hold_viol = hold_viol + 1;
            prev_hold = rd_valid && !rd_ready;
            prev_data = rd_data;
            if (rd_valid && rd_ready) begin
                rd_got[rd_n % 32] = rd_data;
                rd_n = rd_n + 1;
            end
            if (wr_valid && wr_ready) wptr = wptr + 1;
        end
    end

    // Stream drivers away from the edge.
    initial begin
        forever begin
            @(negedge clk);
            wr_valid = ($urandom % 3) != 0;
            wr_data  = wdata[wptr % 32];
            rd_ready = ($urandom % 3) != 0;
        end
    end

    task automatic chk(bit ok, string tag, string what, int act, int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
        end
    endtask

    task automatic push(logic [1:0] op, logic [7:0] b, logic a);
        exp_q[exp_n % 64] = {op, b, a};
        exp_n++;
    endtask

    // Expected command list and status from the requirements.
    task automatic build_exp(int op, logic [6:0] dev, logic [31:0] ra, int alen,
                             int len, bit rep, logic [31:0] nv);
        int   wi = 0;
        logic [6:0] fd;
        logic [63:0] ext;
        exp_n = 0; exp_err = 0; exp_nk = 0; exp_wused = 0; exp_rcnt = 0;
        ext = {32'h0, ra} >> (alen * 8);
        fd  = dev | (ext[6:0] & MASK);
        push(2'd0, 8'h00, 1'b0);
        if (!(op == 1 && alen == 0)) begin
            push(2'd2, {fd, 1'b0}, 1'b0);
            if (nv[wi]) begin push(2'd1, 8'h00, 1'b0); exp_err = 1; return; end
            wi++;
            if (op == 2) begin push(2'd1, 8'h00, 1'b0); return; end
            for (int i = alen - 1; i >= 0; i--) begin
                push(2'd2, ra[i*8 +: 8], 1'b0);
                if (nv[wi]) begin exp_err = 1; return; end
                wi++;
            end
            if (op == 0) begin
                for (int j = 0; j < len; j++) begin
                    push(2'd2, wdata[j], 1'b0);
                    if (nv[wi]) exp_nk++;
                    wi++;
                end
                exp_wused = len;
                push(2'd1, 8'h00, 1'b0);
                return;
            end
            if (!rep) push(2'd1, 8'h00, 1'b0);
            push(2'd0, 8'h00, 1'b0);
        end
        push(2'd2, {fd, 1'b1}, 1'b0);
        if (nv[wi]) begin push(2'd1, 8'h00, 1'b0); exp_err = 1; return; end
        for (int j = 0; j < len; j++) push(2'd3, 8'h00, (j == len - 1));
        exp_rcnt = len;
        push(2'd1, 8'h00, 1'b0);
    endtask

    task automatic run_txn(string tag, int op, logic [6:0] dev, logic [31:0] ra,
                           int alen, int len, bit rep, logic [31:0] nv);
        int t = 0;
        if (hung) return;
        @(negedge clk);
        for (int i = 0; i < 32; i++) wdata[i] = 8'($urandom);
        log_n = 0; widx = 0; ridx = 0; rd_n = 0; wptr = 0;
        nack_vec = nv;
        build_exp(op, dev, ra, alen, len, rep, nv);
        req_valid = 1; req_op = 2'(op); req_dev = dev; req_reg_addr = ra;
        req_alen = 3'(alen); req_len = 8'(len); cfg_rep_start = rep;
        @(negedge clk);
        req_valid = 0;
        chk(req_ready == 1'b0, "R10", "ready while busy", int'(req_ready), 0);
        while (!done && t < 3000) begin @(negedge clk); t++; end
        if (!done) begin
            chk(1'b0, tag, "watchdog", 0, 1);
            hung = 1;
            return;
        end
        chk(st_err == exp_err, tag, "st_err", int'(st_err), int'(exp_err));
        chk(int'(st_nacks) == exp_nk, tag, "st_nacks", int'(st_nacks), exp_nk);
        chk(log_n == exp_n, tag, "command count", log_n, exp_n);
        for (int i = 0; i < exp_n && i < log_n; i++)
            chk(log_q[i] == exp_q[i], tag, $sformatf("command %0d", i),
                int'(log_q[i]), int'(exp_q[i]));
        chk(rd_n == exp_rcnt, "R12", "read count", rd_n, exp_rcnt);
        for (int i = 0; i < exp_rcnt && i < rd_n; i++)
            chk(rd_got[i] == rexp(i), "R12", "read byte", int'(rd_got[i]), int'(rexp(i)));
        if (!exp_err || op == 0)
            chk(wptr == exp_wused, "R13", "write bytes consumed", wptr, exp_wused);
        @(negedge clk);
        chk(done == 1'b0 && req_ready == 1'b1, "R10", "done one cycle", int'(done), 0);
    endtask

    initial begin
        void'($urandom(32'd2718));
        log_n = 0; widx = 0; ridx = 0; rd_n = 0; wptr = 0; pend = 0;
        hold_viol = 0; prev_hold = 0; prev_data = 0; nack_vec = 0;
        repeat (4) @(negedge clk);
        chk(req_ready == 1 && done == 0 && cmd_valid == 0 && rd_valid == 0,
            "R10", "reset state", int'({req_ready, done, cmd_valid}), 4);
        rst_n = 1;
        @(negedge clk);
        run_txn("R1",  1, 7'h50, 32'h0000_1234, 2, 3, 0, 32'h0);
        run_txn("R4",  1, 7'h50, 32'h0000_0077, 1, 1, 0, 32'h0);
        run_txn("R2",  1, 7'h2C, 32'h0000_0000, 0, 2, 0, 32'h0);
        run_txn("R3",  1, 7'h50, 32'h0000_00A5, 1, 2, 1, 32'h0);
        run_txn("R5",  0, 7'h10, 32'h0000_0001, 1, 3, 0, 32'h1);
        run_txn("R5",  1, 7'h10, 32'h0000_0001, 1, 3, 1, 32'h4);
        run_txn("R6",  1, 7'h50, 32'h0000_ABCD, 2, 2, 0, 32'h2);
        run_txn("R7",  0, 7'h50, 32'h0000_0102, 2, 4, 0, 32'h28);
        run_txn("R7",  0, 7'h50, 32'h0000_0003, 1, 3, 0, 32'h10);
        run_txn("R8",  2, 7'h48, 32'h0, 0, 0, 0, 32'h0);
        run_txn("R8",  2, 7'h48, 32'h0, 0, 0, 0, 32'h1);
        run_txn("R9",  0, 7'h50, 32'h0000_0312, 1, 1, 0, 32'h0);
        run_txn("R9",  1, 7'h54, 32'hFF00_0000, 3, 1, 1, 32'h0);
        run_txn("R11", 0, 7'h50, 32'h0000_0044, 1, 0, 0, 32'h0);
        run_txn("R14", 0, 7'h50, 32'h1122_3344, 4, 2, 0, 32'h0);
        for (int n = 0; n < 60; n++) begin
            int op = int'($urandom % 3);
            logic [31:0] nv = 0;
            for (int b = 0; b < 32; b++) nv[b] = ($urandom % 8) == 0;
            run_txn(op == 0 ? "R7" : (op == 1 ? "R1" : "R8"), op, 7'($urandom),
                    $urandom, int'($urandom % 5), int'($urandom % 7),
                    bit'($urandom % 2), nv);
        end
        chk(hold_viol == 0, "R12", "read data held under stall", hold_viol, 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule